// File: doc/BRIEF.md
# Repeating Calendar Alarm Comparator

This block watches a running calendar (month, day of month, hour, minute and second, each a two-digit BCD byte) and raises an alarm flag when that time agrees with a programmed alarm time. A five-bit repeat code chooses how many of the fields take part in the comparison. Depending on the code, the alarm fires every second, once a minute, once an hour, once a day, once a month or once a year. The comparison is made only when the calendar's once-per-second update strobe is high, so an alarm is raised at most once per second.

Software programs the five alarm bytes and a control byte through a simple write port. The control byte holds the interrupt enable and the repeat code. The host reads the flag. A read strobe for the flags location clears the flag, and with it the active-low interrupt request. While the host's address pointer rests on the flags location, a new match is held back. It is delivered once the pointer moves away, so a match that arrives in the middle of a flags read is not lost.

Top module: `alarm_matcher`

## Requirements
- R1: Writes with `wr_en` high store `wr_data` in the location chosen by `wr_sel`. The selector codes are: 0 alarm month, 1 alarm day-of-month, 2 alarm hour, 3 alarm minute, 4 alarm second, and 5 control. In the control byte, bit 7 is the interrupt enable and bits 4:0 are the repeat code. All time fields are BCD.
- R2: The repeat code selects the fields that are compared:
  - 11111: no field is compared (every second).
  - 11110: second only.
  - 11100: minute and second.
  - 11000: hour, minute and second.
  - 10000: day-of-month, hour, minute and second.
  - 00000: all five fields.
- R3: Any other repeat code behaves exactly like 11111.
- R4: A match is evaluated only in a cycle where `tick` is high. The resulting `alarm_flag` is visible from the cycle after that clock edge. A match with `tick` low has no effect.
- R5: `irq_n` is low exactly when `alarm_flag` is 1 and the enable bit is 1. Otherwise it is high.
- R6: A cycle with `flag_rd` high clears `alarm_flag` and releases `irq_n` from the next cycle on. During the read cycle itself, `alarm_flag` still shows the value it had before the clear.
- R7: A match evaluated while `ptr_at_flags` is high leaves `alarm_flag` at 0. It is remembered and sets `alarm_flag` in the cycle after the first clock edge at which `ptr_at_flags` is low.
- R8: With the alarm day-of-month byte at 00 and the repeat code at 00000, the alarm never fires, even when every field agrees with the current time.
- R9: If a match sets the flag in the same cycle as `flag_rd` is high, the set wins and `alarm_flag` stays 1.
- R10: After synchronous reset, all alarm bytes and the control byte are 0, `alarm_flag` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Once-per-second calendar update strobe |
| now_mon | input | 8 | Current month, BCD |
| now_date | input | 8 | Current day of month, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_sec | input | 8 | Current second, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | 8 | Register write data |
| flag_rd | input | 1 | Flags-location read strobe |
| ptr_at_flags | input | 1 | Host address pointer rests on the flags location |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Active-low interrupt request (pull-down enable of an open-drain pin) |

## Verification
Two functions can fall in one cycle. A fresh match can arrive in the same cycle as a read strobe that clears the flag. A held-back match can also be released by the pointer leaving the flags location while a read is in progress. The bench sets the flag, then raises `flag_rd` together with a matching `tick`, and expects the flag to stay set. It also holds a match back, drops `ptr_at_flags` in a read cycle, and expects the flag to appear. Around these cases, a sweep covers all 32 repeat codes against all 32 patterns of which fields agree.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int FIELD_W = 8;
    localparam int RPT_W   = 5;
    localparam int SEL_W   = 3;
    localparam int EN_BIT  = 7;

    localparam logic [SEL_W-1:0] SEL_MON  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DATE = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HOUR = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MIN  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SEC  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

    typedef enum logic [2:0] {
        RM_SEC, RM_MIN, RM_HOUR, RM_DAY, RM_MONTH, RM_YEAR
    } rpt_mode_e;

    typedef struct packed {
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic             irq_en;
        logic [RPT_W-1:0] rpt;
    } alarm_ctrl_t;

    // compared-field mask order: {mon, date, hour, min, sec}
    typedef logic [4:0] field_mask_t;

    function automatic rpt_mode_e decode_rpt(input logic [RPT_W-1:0] code);
        case (code)
            5'b11110: return RM_MIN;
            5'b11100: return RM_HOUR;
            5'b11000: return RM_DAY;
            5'b10000: return RM_MONTH;
            5'b00000: return RM_YEAR;
            default:  return RM_SEC;
        endcase
    endfunction

    function automatic field_mask_t mode_mask(input rpt_mode_e m);
        case (m)
            RM_MIN:   return 5'b00001;
            RM_HOUR:  return 5'b00011;
            RM_DAY:   return 5'b00111;
            RM_MONTH: return 5'b01111;
            RM_YEAR:  return 5'b11111;
            default:  return 5'b00000;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output cal_time_t          alm,
    output alarm_ctrl_t        ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            alm  <= '0;
            ctrl <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MON:  alm.mon  <= wr_data;
                SEL_DATE: alm.date <= wr_data;
                SEL_HOUR: alm.hour <= wr_data;
                SEL_MIN:  alm.min  <= wr_data;
                SEL_SEC:  alm.sec  <= wr_data;
                SEL_CTRL: begin
                    ctrl.irq_en <= wr_data[EN_BIT];
                    ctrl.rpt    <= wr_data[RPT_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_pkg::*;
(
    input  cal_time_t        now,
    input  cal_time_t        alm,
    input  logic [RPT_W-1:0] rpt,
    output logic             match
);
    localparam int NF = 5;

    field_mask_t need;
    logic [NF-1:0] eq;
    logic disabled;

    assign need = mode_mask(decode_rpt(rpt));

    generate
        for (genvar f = 0; f < NF; f++) begin : g_eq
            assign eq[f] = (now[f*FIELD_W +: FIELD_W] == alm[f*FIELD_W +: FIELD_W]);
        end
    endgenerate

    assign disabled = (alm.date == '0) && (rpt == '0);

    always_comb begin
        match = !disabled && ((eq | ~need) == '1);
    end
endmodule

// File: rtl/alarm_flagctl.sv
module alarm_flagctl (
    input  logic clk,
    input  logic rst,
    input  logic hit_evt,
    input  logic ptr_at_flags,
    input  logic flag_rd,
    output logic af
);
    logic pend;
    logic set_now;
    logic release_now;

    assign set_now     = hit_evt && !ptr_at_flags;
    assign release_now = pend && !ptr_at_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            af   <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (hit_evt && ptr_at_flags) pend <= 1'b1;
            else if (release_now)        pend <= 1'b0;

            if (set_now || release_now) af <= 1'b1;
            else if (flag_rd)           af <= 1'b0;
        end
    end

    // R4
    af_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(hit_evt || pend));
    // R7
    no_set_while_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_at_flags && !af) |=> !af);
    // R7
    pend_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !ptr_at_flags) |=> af);
    // R6
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !hit_evt && !pend) |=> !af);
    // R9
    set_beats_read_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && hit_evt && !ptr_at_flags) |=> af);
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [FIELD_W-1:0] now_mon,
    input  logic [FIELD_W-1:0] now_date,
    input  logic [FIELD_W-1:0] now_hour,
    input  logic [FIELD_W-1:0] now_min,
    input  logic [FIELD_W-1:0] now_sec,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               flag_rd,
    input  logic               ptr_at_flags,
    output logic               alarm_flag,
    output logic               irq_n
);
    cal_time_t   now;
    cal_time_t   alm;
    alarm_ctrl_t ctrl;
    logic        match;
    logic        hit_evt;

    assign now = '{mon: now_mon, date: now_date, hour: now_hour, min: now_min, sec: now_sec};

    alarm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .alm(alm), .ctrl(ctrl)
    );

    alarm_compare u_cmp (
        .now(now), .alm(alm), .rpt(ctrl.rpt), .match(match)
    );

    assign hit_evt = tick && match;

    alarm_flagctl u_flag (
        .clk(clk), .rst(rst), .hit_evt(hit_evt),
        .ptr_at_flags(ptr_at_flags), .flag_rd(flag_rd), .af(alarm_flag)
    );

    assign irq_n = !(alarm_flag && ctrl.irq_en);

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> alarm_flag);
    // R4
    no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !alarm_flag && !ptr_at_flags && !$past(ptr_at_flags)) |=> !alarm_flag);
endmodule

// File: tb/alarm_matcher_test.sv
module alarm_matcher_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] now_mon = 8'h00, now_date = 8'h00, now_hour = 8'h00, now_min = 8'h00, now_sec = 8'h00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_rd = 1'b0;
    logic       ptr_at_flags = 1'b0;
    logic       alarm_flag;
    logic       irq_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // alarm time used in the sweep
    localparam logic [7:0] A_MON = 8'h12, A_DATE = 8'h31, A_HOUR = 8'h23, A_MIN = 8'h59, A_SEC = 8'h58;
    // differing values
    localparam logic [7:0] D_MON = 8'h11, D_DATE = 8'h30, D_HOUR = 8'h22, D_MIN = 8'h58, D_SEC = 8'h57;

    always #4 clk = ~clk;

    alarm_matcher uut (
        .clk(clk), .rst(rst), .tick(tick),
        .now_mon(now_mon), .now_date(now_date), .now_hour(now_hour),
        .now_min(now_min), .now_sec(now_sec),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_rd(flag_rd), .ptr_at_flags(ptr_at_flags),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_now(input logic [7:0] m, d, h, mi, s);
        now_mon = m; now_date = d; now_hour = h; now_min = mi; now_sec = s;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    function automatic logic [4:0] need_of(input logic [4:0] code);
        if (code == 5'b11110) return 5'b00001;
        if (code == 5'b11100) return 5'b00011;
        if (code == 5'b11000) return 5'b00111;
        if (code == 5'b10000) return 5'b01111;
        if (code == 5'b00000) return 5'b11111;
        return 5'b00000;
    endfunction

    task automatic apply_diff(input logic [4:0] diff);
        set_now(diff[4] ? D_MON : A_MON, diff[3] ? D_DATE : A_DATE,
                diff[2] ? D_HOUR : A_HOUR, diff[1] ? D_MIN : A_MIN,
                diff[0] ? D_SEC : A_SEC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(alarm_flag == 1'b0, "R10 flag after reset", alarm_flag, 0);
        check(irq_n == 1'b1, "R10 irq_n after reset", irq_n, 1);
        rst = 1'b0;
        @(negedge clk);
        // R10/R8: registers zero -> disabled, matching zero time must not fire
        set_now(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        pulse_tick();
        check(alarm_flag == 1'b0, "R10 R8 zero regs do not fire", alarm_flag, 0);

        // R1 program alarm time
        wreg(3'd0, A_MON); wreg(3'd1, A_DATE); wreg(3'd2, A_HOUR);
        wreg(3'd3, A_MIN); wreg(3'd4, A_SEC);

        // R2 R3 sweep: all codes x all diff patterns
        for (int code = 0; code < 32; code++) begin
            wreg(3'd5, {3'b000, code[4:0]});
            for (int diff = 0; diff < 32; diff++) begin
                logic exp;
                exp = ((diff[4:0] & need_of(code[4:0])) == 5'b0);
                apply_diff(diff[4:0]);
                pulse_tick();
                check(alarm_flag == exp, "R2 R3 R1 repeat sweep", alarm_flag, exp);
                clear_flag();
            end
        end

        // R4: full match but no tick
        wreg(3'd5, 8'h00);
        apply_diff(5'b0);
        repeat (4) @(negedge clk);
        check(alarm_flag == 1'b0, "R4 no tick no flag", alarm_flag, 0);
        // R4 timing: flag not visible in tick cycle, visible after edge
        @(negedge clk); tick = 1'b1; #1;
        check(alarm_flag == 1'b0, "R4 flag not yet in tick cycle", alarm_flag, 0);
        @(negedge clk); tick = 1'b0;
        check(alarm_flag == 1'b1, "R4 flag after tick edge", alarm_flag, 1);
        // R5 enable off -> irq high
        check(irq_n == 1'b1, "R5 irq released when disabled", irq_n, 1);
        // R5 enable on -> irq low
        wreg(3'd5, 8'h80);
        check(irq_n == 1'b0, "R5 irq low with flag and enable", irq_n, 0);
        // R6: read shows old value then clears
        @(negedge clk); flag_rd = 1'b1; #1;
        check(alarm_flag == 1'b1, "R6 flag during read cycle", alarm_flag, 1);
        @(negedge clk); flag_rd = 1'b0;
        check(alarm_flag == 1'b0, "R6 flag cleared after read", alarm_flag, 0);
        check(irq_n == 1'b1, "R6 irq released after read", irq_n, 1);

        // R9: set and read in the same cycle
        pulse_tick();
        check(alarm_flag == 1'b1, "R9 preset flag", alarm_flag, 1);
        @(negedge clk); flag_rd = 1'b1; tick = 1'b1;
        @(negedge clk); flag_rd = 1'b0; tick = 1'b0;
        check(alarm_flag == 1'b1, "R9 set wins over read", alarm_flag, 1);
        check(irq_n == 1'b0, "R9 irq stays low", irq_n, 0);
        clear_flag();

        // R7: hold off while pointer at flags
        @(negedge clk); ptr_at_flags = 1'b1;
        pulse_tick();
        repeat (3) @(negedge clk);
        check(alarm_flag == 1'b0, "R7 held off at flags pointer", alarm_flag, 0);
        check(irq_n == 1'b1, "R7 irq held off", irq_n, 1);
        // pointer leaves during a read cycle: held event still delivered
        @(negedge clk); ptr_at_flags = 1'b0; flag_rd = 1'b1; #1;
        check(alarm_flag == 1'b0, "R7 not yet in release cycle", alarm_flag, 0);
        @(negedge clk); flag_rd = 1'b0;
        check(alarm_flag == 1'b1, "R7 R9 delivered after pointer leaves", alarm_flag, 1);
        clear_flag();
        check(alarm_flag == 1'b0, "R6 cleared again", alarm_flag, 0);

        // R8: date 00 and code 00000 disables, even with full agreement
        wreg(3'd1, 8'h00); wreg(3'd5, 8'h80);
        set_now(A_MON, 8'h00, A_HOUR, A_MIN, A_SEC);
        pulse_tick();
        check(alarm_flag == 1'b0, "R8 disabled alarm", alarm_flag, 0);
        // R8 counterpart: date 00 with per-second code still fires
        wreg(3'd5, 8'h9F);
        pulse_tick();
        check(alarm_flag == 1'b1, "R8 date zero per-second still fires", alarm_flag, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule